// File: doc/BRIEF.md
# Clock Select Register Bank

This block is the register bank of a clock control unit. It holds the divider-ratio codes and source-select codes that steer the clock tree. Software reaches it through a simple word-addressed write port and a combinational read port. Each code sits in a bit field of a 32-bit word. The top bit of every field is that field's own write enable, so a single write can update any subset of the fields in a word and leave the rest alone. The clock generators and the glitch-free switching stages are not part of this block. They take the decoded ratio and source-index outputs.

Fields in registers 1 and 8 change the outputs on the clock edge that accepts the write. Fields in registers 9 and 10 are double-buffered. A write lands in a staged copy, and the outputs keep the previous setting until software writes a change request to register 11. Register 11 then reads 1 for a fixed number of cycles. On the cycle it returns to 0, the staged codes become active. A code outside a field's table is refused: that field keeps its setting, and a sticky error bit is set in register 12.

Top module: `ccu_clksel_bank`

## Requirements
- R1: Register n (n from 1) is at byte offset (n-1)*4. Mapped registers are 1, 8, 9, 10, 11 and 12. An access whose low two address bits are not zero, or whose offset is unmapped, reads 0, and a write to it changes nothing.
- R2: Each field changes only when its top bit is 1 in the written word. The new code is taken from the bits below that top bit.
- R3: Register 1 and register 8 fields drive the outputs from the clock edge that accepts the write.
- R4: Register 9 and register 10 fields are staged. A write does not change the outputs, and a read of the register returns the staged codes.
- R5: Writing register 11 with bit 0 set starts a commit if none is pending. Register 11 then reads 1 for exactly COMMIT_CYCLES cycles and then reads 0. The staged codes reach the outputs on the same edge that clears it. A request made while a commit is pending is ignored. A write with bit 0 clear starts nothing.
- R6: Divider decode from code to ratio:
  - tick (reg1 [2:0]): 0/1/2/3 → 8/16/24/32.
  - card (reg1 [30:28]): 0/1/2/3 → 8/9/10/15.
  - periph (reg9 [6:0]): 15→16, 31→32.
  - host (reg9 [11:7]): 7→8, 15→16.
  - bridge (reg9 [15:12]) and core (reg9 [23:20]): 3→4, 7→8.
  - ext (reg9 [19:16]): 3/4/5/7 → 4/5/6/8.
  - fab (reg10 [2:0]) and memhi (reg10 [9:7]): 1→2, 3→4.
  - memlo (reg10 [6:3]): 3→4, 7→8.
- R7: Source-select decode. The flash field (reg1 [27:22]) maps codes 0,1,2,3,4,8 to sources 0..5. The serial field (reg8 [5:3]) maps codes 0,1,2 to sources 0..2.
- R8: A write-enabled field that carries a code outside its table keeps its setting and sets the sticky error bit, register 12 bit 0. Other fields in the same write still update. Writing 1 to register 12 bit 0 clears the error bit.
- R9: After reset:
  - each field holds its first table code: tick 0, card 0, flash 0, serial 0, periph 15, host 7, bridge 3, ext 3, core 3, fab 1, memhi 1, memlo 3;
  - no commit is pending;
  - the error bit is 0.
- R10: A read returns each field's code in its value bits. Write-enable bits and unused bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | ADDR_W | Byte offset for write and read |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| tick_ratio | output | RATIO_W | Timer divider ratio |
| card_ratio | output | RATIO_W | Card clock divider ratio |
| flash_src | output | 3 | Flash clock source index |
| serial_src | output | 2 | Serial clock source index |
| periph_ratio | output | RATIO_W | Peripheral divider ratio |
| host_ratio | output | RATIO_W | Host bus divider ratio |
| bridge_ratio | output | RATIO_W | Bridge divider ratio |
| ext_ratio | output | RATIO_W | External bus divider ratio |
| core_ratio | output | RATIO_W | Core bus divider ratio |
| memhi_ratio | output | RATIO_W | Fast memory divider ratio |
| memlo_ratio | output | RATIO_W | Slow memory divider ratio |
| fab_ratio | output | RATIO_W | Fabric divider ratio |

## Verification
The assertions take several things for granted about the inputs:
- bus_wr is a single-cycle strobe, and its address and data hold steady across the sampling edge;
- reset is held for at least one edge;
- software waits for register 11 to clear before it relies on a staged value.

The stimulus keeps to these rules. It drives the port on the falling edge. Most written codes are drawn from each field's legal table, with a minority left random so that refusals also occur. Each commit is polled to completion before the outputs are compared, so every active value the checks see follows from a finished handshake.

// File: rtl/ccu_clksel_pkg.sv
package ccu_clksel_pkg;

    localparam int DATA_W     = 32;
    localparam int CODE_W     = 6;
    localparam int RATIO_W    = 6;
    localparam int NUM_FIELDS = 12;
    localparam int REG_COMMIT = 11;
    localparam int REG_STATUS = 12;

    typedef enum logic [3:0] {
        F_TICK, F_CARD, F_FLASH, F_SERIAL, F_PERIPH, F_HOST,
        F_BRIDGE, F_EXT, F_CORE, F_MEMHI, F_MEMLO, F_FAB
    } field_e;

    typedef struct packed {
        logic               ok;
        logic [RATIO_W-1:0] val;
    } decode_t;

    function automatic int fld_reg(input int i);
        case (i)
            0, 1, 2:       return 1;
            3:             return 8;
            4, 5, 6, 7, 8: return 9;
            default:       return 10;
        endcase
    endfunction

    function automatic int fld_lsb(input int i);
        case (i)
            0: return 0;   1: return 28;  2: return 22;  3: return 3;
            4: return 0;   5: return 7;   6: return 12;  7: return 16;
            8: return 20;  9: return 7;   10: return 3;  default: return 0;
        endcase
    endfunction

    function automatic int fld_width(input int i);
        case (i)
            0, 1, 3, 9, 11: return 3;
            2:              return 6;
            4:              return 7;
            5:              return 5;
            default:        return 4;
        endcase
    endfunction

    function automatic bit fld_staged(input int i);
        return fld_reg(i) >= 9;
    endfunction

    function automatic int fld_reset(input int i);
        case (i)
            4:              return 15;
            5:              return 7;
            6, 7, 8, 10:    return 3;
            9, 11:          return 1;
            default:        return 0;
        endcase
    endfunction

    function automatic decode_t ok_val(input int v);
        decode_t d;
        d.ok  = 1'b1;
        d.val = RATIO_W'(v);
        return d;
    endfunction

    function automatic decode_t fld_decode(input field_e f, input logic [CODE_W-1:0] code);
        decode_t d;
        d = '0;
        case (f)
            F_TICK:   case (code) 0: d = ok_val(8);  1: d = ok_val(16); 2: d = ok_val(24); 3: d = ok_val(32); default: ; endcase
            F_CARD:   case (code) 0: d = ok_val(8);  1: d = ok_val(9);  2: d = ok_val(10); 3: d = ok_val(15); default: ; endcase
            F_FLASH:  case (code) 0: d = ok_val(0);  1: d = ok_val(1);  2: d = ok_val(2);  3: d = ok_val(3);
                                  4: d = ok_val(4);  8: d = ok_val(5);  default: ; endcase
            F_SERIAL: case (code) 0: d = ok_val(0);  1: d = ok_val(1);  2: d = ok_val(2);  default: ; endcase
            F_PERIPH: case (code) 15: d = ok_val(16); 31: d = ok_val(32); default: ; endcase
            F_HOST:   case (code) 7: d = ok_val(8);  15: d = ok_val(16); default: ; endcase
            F_EXT:    case (code) 3: d = ok_val(4);  4: d = ok_val(5);  5: d = ok_val(6);  7: d = ok_val(8); default: ; endcase
            F_MEMHI,
            F_FAB:    case (code) 1: d = ok_val(2);  3: d = ok_val(4);  default: ; endcase
            default:  case (code) 3: d = ok_val(4);  7: d = ok_val(8);  default: ; endcase
        endcase
        return d;
    endfunction

endpackage

// File: rtl/ccu_clksel_field.sv
module ccu_clksel_field
    import ccu_clksel_pkg::*;
#(
    parameter int FIELD      = 0,
    parameter int LSB        = 0,
    parameter int WIDTH      = 3,
    parameter bit STAGED     = 1'b0,
    parameter int RESET_CODE = 0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_hit,
    input  logic [DATA_W-1:0] wdata,
    input  logic              apply,
    output logic [CODE_W-1:0] staged_code,
    output logic [CODE_W-1:0] active_code,
    output logic              bad_wr
);
    localparam int VAL_W  = WIDTH - 1;
    localparam int WE_BIT = LSB + WIDTH - 1;

    logic              fld_we;
    logic [CODE_W-1:0] new_code;
    decode_t           new_dec;
    logic              accept;

    assign fld_we   = wr_hit && wdata[WE_BIT];
    assign new_code = CODE_W'(wdata[LSB +: VAL_W]);
    assign new_dec  = fld_decode(field_e'(4'(FIELD)), new_code);
    assign accept   = fld_we && new_dec.ok;
    assign bad_wr   = fld_we && !new_dec.ok;

    always_ff @(posedge clk) begin
        if (rst) begin
            staged_code <= CODE_W'(RESET_CODE);
        end else if (accept) begin
            staged_code <= new_code;
        end
    end

    generate
        if (STAGED) begin : g_double
            always_ff @(posedge clk) begin
                if (rst) begin
                    active_code <= CODE_W'(RESET_CODE);
                end else if (apply) begin
                    active_code <= staged_code;
                end
            end

            // R4: a staged field never moves the output without a commit
            assert_staged_hold_R4: assert property (@(posedge clk) disable iff (rst)
                !apply |=> $stable(active_code));
        end else begin : g_direct
            assign active_code = staged_code;
        end
    endgenerate

    // R2: no write-enable bit, no change
    assert_we_gate_R2: assert property (@(posedge clk) disable iff (rst)
        !(wr_hit && wdata[WE_BIT]) |=> $stable(staged_code));

    // R8: refused code leaves the field alone
    assert_bad_keeps_R8: assert property (@(posedge clk) disable iff (rst)
        bad_wr |=> $stable(staged_code));

    // R6: the active code always decodes
    assert_active_legal_R6: assert property (@(posedge clk) disable iff (rst)
        fld_decode(field_e'(4'(FIELD)), active_code).ok);

endmodule

// File: rtl/ccu_commit_ctrl.sv
module ccu_commit_ctrl #(
    parameter int CYCLES = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic req,
    output logic pending,
    output logic apply
);
    localparam int CNT_W = $clog2(CYCLES + 1);

    logic [CNT_W-1:0] cnt;

    assign apply = pending && (cnt == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            pending <= 1'b0;
            cnt     <= '0;
        end else if (!pending) begin
            if (req) begin
                pending <= 1'b1;
                cnt     <= CNT_W'(CYCLES - 1);
            end
        end else if (cnt == '0) begin
            pending <= 1'b0;
        end else begin
            cnt <= cnt - 1'b1;
        end
    end

    // R5: an idle request loads a full window
    assert_req_loads_R5: assert property (@(posedge clk) disable iff (rst)
        (req && !pending) |=> (pending && cnt == CNT_W'(CYCLES - 1)));

    // R5: pending holds until the apply cycle
    assert_pending_holds_R5: assert property (@(posedge clk) disable iff (rst)
        (pending && !apply) |=> pending);

    // R5: apply ends the commit
    assert_apply_ends_R5: assert property (@(posedge clk) disable iff (rst)
        apply |=> !pending);

endmodule

// File: rtl/ccu_clksel_bank.sv
module ccu_clksel_bank
    import ccu_clksel_pkg::*;
#(
    parameter int ADDR_W        = 8,
    parameter int COMMIT_CYCLES = 16
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               bus_wr,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [DATA_W-1:0]  bus_wdata,
    output logic [DATA_W-1:0]  bus_rdata,
    output logic [RATIO_W-1:0] tick_ratio,
    output logic [RATIO_W-1:0] card_ratio,
    output logic [2:0]         flash_src,
    output logic [1:0]         serial_src,
    output logic [RATIO_W-1:0] periph_ratio,
    output logic [RATIO_W-1:0] host_ratio,
    output logic [RATIO_W-1:0] bridge_ratio,
    output logic [RATIO_W-1:0] ext_ratio,
    output logic [RATIO_W-1:0] core_ratio,
    output logic [RATIO_W-1:0] memhi_ratio,
    output logic [RATIO_W-1:0] memlo_ratio,
    output logic [RATIO_W-1:0] fab_ratio
);
    localparam int WIDX_W = ADDR_W - 2;

    logic                                  aligned;
    logic [WIDX_W-1:0]                     word_idx;
    logic [NUM_FIELDS-1:0][CODE_W-1:0]     staged_codes;
    logic [NUM_FIELDS-1:0][CODE_W-1:0]     active_codes;
    logic [NUM_FIELDS-1:0]                 bad_wr;
    logic                                  commit_req;
    logic                                  pending;
    logic                                  apply;
    logic                                  err_q;
    logic                                  err_clr;
    decode_t                               dec [NUM_FIELDS];

    assign aligned  = (bus_addr[1:0] == 2'b00);
    assign word_idx = bus_addr[ADDR_W-1:2];

    assign commit_req = bus_wr && aligned && bus_wdata[0] &&
                        (word_idx == WIDX_W'(REG_COMMIT - 1));
    assign err_clr    = bus_wr && aligned && bus_wdata[0] &&
                        (word_idx == WIDX_W'(REG_STATUS - 1));

    generate
        for (genvar g = 0; g < NUM_FIELDS; g++) begin : g_field
            logic hit;
            assign hit = bus_wr && aligned && (word_idx == WIDX_W'(fld_reg(g) - 1));

            ccu_clksel_field #(
                .FIELD      (g),
                .LSB        (fld_lsb(g)),
                .WIDTH      (fld_width(g)),
                .STAGED     (fld_staged(g)),
                .RESET_CODE (fld_reset(g))
            ) u_field (
                .clk         (clk),
                .rst         (rst),
                .wr_hit      (hit),
                .wdata       (bus_wdata),
                .apply       (apply),
                .staged_code (staged_codes[g]),
                .active_code (active_codes[g]),
                .bad_wr      (bad_wr[g])
            );
        end
    endgenerate

    ccu_commit_ctrl #(
        .CYCLES (COMMIT_CYCLES)
    ) u_commit (
        .clk     (clk),
        .rst     (rst),
        .req     (commit_req),
        .pending (pending),
        .apply   (apply)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            err_q <= 1'b0;
        end else if (|bad_wr) begin
            err_q <= 1'b1;
        end else if (err_clr) begin
            err_q <= 1'b0;
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (aligned) begin
            for (int i = 0; i < NUM_FIELDS; i++) begin
                if (word_idx == WIDX_W'(fld_reg(i) - 1)) begin
                    bus_rdata = bus_rdata | (DATA_W'(staged_codes[i]) << fld_lsb(i));
                end
            end
            if (word_idx == WIDX_W'(REG_COMMIT - 1)) bus_rdata[0] = pending;
            if (word_idx == WIDX_W'(REG_STATUS - 1)) bus_rdata[0] = err_q;
        end
    end

    always_comb begin
        for (int i = 0; i < NUM_FIELDS; i++) begin
            dec[i] = fld_decode(field_e'(4'(i)), active_codes[i]);
        end
    end

    assign tick_ratio   = dec[0].val;
    assign card_ratio   = dec[1].val;
    assign flash_src    = dec[2].val[2:0];
    assign serial_src   = dec[3].val[1:0];
    assign periph_ratio = dec[4].val;
    assign host_ratio   = dec[5].val;
    assign bridge_ratio = dec[6].val;
    assign ext_ratio    = dec[7].val;
    assign core_ratio   = dec[8].val;
    assign memhi_ratio  = dec[9].val;
    assign memlo_ratio  = dec[10].val;
    assign fab_ratio    = dec[11].val;

    // R8: error flag is set by any refused field
    assert_err_sets_R8: assert property (@(posedge clk) disable iff (rst)
        (|bad_wr) |=> err_q);

    // R8: error flag only clears through the status register
    assert_err_sticky_R8: assert property (@(posedge clk) disable iff (rst)
        (err_q && !err_clr) |=> err_q);

    // R1: a misaligned write touches no field
    assert_misaligned_R1: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && !aligned) |=> $stable(staged_codes));

    // R1: a misaligned read returns zero
    assert_misaligned_read_R1: assert property (@(posedge clk) disable iff (rst)
        !aligned |-> (bus_rdata == '0));

endmodule

// File: tb/ccu_clksel_bank_bench.sv
module ccu_clksel_bank_bench;

    localparam int COMMIT = 16;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [5:0]  tick_ratio, card_ratio, periph_ratio, host_ratio, bridge_ratio;
    logic [5:0]  ext_ratio, core_ratio, memhi_ratio, memlo_ratio, fab_ratio;
    logic [2:0]  flash_src;
    logic [1:0]  serial_src;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    int m_stg [12];
    int m_act [12];
    bit m_err;

    always #10 clk = ~clk;

    ccu_clksel_bank #(.ADDR_W(8), .COMMIT_CYCLES(COMMIT)) u_ccu_clksel_bank (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .tick_ratio(tick_ratio), .card_ratio(card_ratio), .flash_src(flash_src),
        .serial_src(serial_src), .periph_ratio(periph_ratio), .host_ratio(host_ratio),
        .bridge_ratio(bridge_ratio), .ext_ratio(ext_ratio), .core_ratio(core_ratio),
        .memhi_ratio(memhi_ratio), .memlo_ratio(memlo_ratio), .fab_ratio(fab_ratio)
    );

    // Field tables restated from the requirements
    function automatic int b_reg(input int f);
        if (f <= 2) return 1;
        if (f == 3) return 8;
        if (f <= 8) return 9;
        return 10;
    endfunction

    function automatic int b_lsb(input int f);
        int t [12] = '{0, 28, 22, 3, 0, 7, 12, 16, 20, 7, 3, 0};
        return t[f];
    endfunction

    function automatic int b_w(input int f);
        int t [12] = '{3, 3, 6, 3, 7, 5, 4, 4, 4, 3, 4, 3};
        return t[f];
    endfunction

    function automatic int b_rst(input int f);
        int t [12] = '{0, 0, 0, 0, 15, 7, 3, 3, 3, 1, 3, 1};
        return t[f];
    endfunction

    function automatic int b_dec(input int f, input int c);
        case (f)
            0: if (c <= 3) return (c + 1) * 8;
            1: if (c <= 3) return (c == 3) ? 15 : 8 + c;
            2: if (c <= 4) return c; else if (c == 8) return 5;
            3: if (c <= 2) return c;
            4: if (c == 15 || c == 31) return c + 1;
            5: if (c == 7 || c == 15) return c + 1;
            7: if (c == 3 || c == 4 || c == 5 || c == 7) return c + 1;
            9, 11: if (c == 1 || c == 3) return c + 1;
            default: if (c == 3 || c == 7) return c + 1;
        endcase
        return -1;
    endfunction

    function automatic int b_pick(input int f, input int unsigned r);
        int fl [6] = '{0, 1, 2, 3, 4, 8};
        int ex [4] = '{3, 4, 5, 7};
        case (f)
            0, 1: return int'(r % 4);
            2:    return fl[r % 6];
            3:    return int'(r % 3);
            4:    return (r % 2 == 0) ? 15 : 31;
            5:    return (r % 2 == 0) ? 7 : 15;
            7:    return ex[r % 4];
            9, 11: return (r % 2 == 0) ? 1 : 3;
            default: return (r % 2 == 0) ? 3 : 7;
        endcase
    endfunction

    function automatic int get_out(input int f);
        case (f)
            0: return int'(tick_ratio);    1: return int'(card_ratio);
            2: return int'(flash_src);     3: return int'(serial_src);
            4: return int'(periph_ratio);  5: return int'(host_ratio);
            6: return int'(bridge_ratio);  7: return int'(ext_ratio);
            8: return int'(core_ratio);    9: return int'(memhi_ratio);
            10: return int'(memlo_ratio);  default: return int'(fab_ratio);
        endcase
    endfunction

    function automatic logic [31:0] exp_rd(input logic [7:0] a);
        logic [31:0] v = '0;
        int n;
        if (a[1:0] != 2'b00) return '0;
        n = int'(a[7:2]) + 1;
        for (int f = 0; f < 12; f++)
            if (b_reg(f) == n) v = v | (32'(m_stg[f]) << b_lsb(f));
        if (n == 12) v = {31'b0, m_err};
        return v;
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic model_write(input logic [7:0] a, input logic [31:0] d);
        int n, w, c;
        if (a[1:0] != 2'b00) return;
        n = int'(a[7:2]) + 1;
        for (int f = 0; f < 12; f++) begin
            if (b_reg(f) == n) begin
                w = b_w(f);
                if (d[b_lsb(f) + w - 1]) begin
                    c = int'((d >> b_lsb(f)) & ((32'd1 << (w - 1)) - 1));
                    if (b_dec(f, c) >= 0) begin
                        m_stg[f] = c;
                        if (n < 9) m_act[f] = c;
                    end else begin
                        m_err = 1'b1;
                    end
                end
            end
        end
        if (n == 12 && d[0] && m_err) begin
            // a clear never coincides with a field write: register 12 has no fields
            m_err = 1'b0;
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        bus_wr    = 1'b1;
        bus_addr  = a;
        bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
        model_write(a, d);
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic check_outs(input string tag);
        for (int f = 0; f < 12; f++)
            chk($sformatf("%s %s field%0d", tag, (f == 2 || f == 3) ? "R7 source" : "R6 ratio", f),
                get_out(f), b_dec(f, m_act[f]));
    endtask

    task automatic check_all(input string tag);
        logic [7:0] addrs [8] = '{8'h00, 8'h1C, 8'h20, 8'h24, 8'h28, 8'h2C, 8'h04, 8'h30};
        logic [31:0] r;
        check_outs(tag);
        for (int i = 0; i < 8; i++) begin
            rd(addrs[i], r);
            chk($sformatf("%s R10 readback 0x%0h", tag, addrs[i]), int'(r), int'(exp_rd(addrs[i])));
        end
    endtask

    task automatic wait_commit(input int k0, input string tag);
        int k = k0;
        logic [31:0] r;
        while (1) begin
            rd(8'h28, r);
            if (r == 0 || k > 100) break;
            chk({tag, " R5 busy reads 1"}, int'(r), 1);
            check_outs({tag, " R4 held during commit"});
            @(negedge clk);
            k++;
        end
        chk({tag, " R5 commit length"}, k, COMMIT);
        for (int f = 4; f < 12; f++) m_act[f] = m_stg[f];
        check_all({tag, " R5 after commit"});
    endtask

    task automatic rand_write();
        logic [7:0] list [10] = '{8'h00, 8'h1C, 8'h20, 8'h24, 8'h2C, 8'h04, 8'h30, 8'h21, 8'h1E, 8'h3C};
        logic [7:0] a;
        logic [31:0] d, mask;
        int n, w, c;
        bit we;
        a = list[$urandom % 10];
        d = $urandom;
        n = int'(a[7:2]) + 1;
        if (a == 8'h2C) d[0] = ($urandom % 4 == 0);
        if (a[1:0] == 2'b00) begin
            for (int f = 0; f < 12; f++) begin
                if (b_reg(f) == n) begin
                    w  = b_w(f);
                    we = ($urandom % 4) != 0;
                    c  = ($urandom % 5 == 0) ? int'($urandom % (32'd1 << (w - 1))) : b_pick(f, $urandom);
                    mask = ((32'd1 << w) - 1) << b_lsb(f);
                    d = (d & ~mask) | (32'(c) << b_lsb(f)) | (32'(we) << (b_lsb(f) + w - 1));
                end
            end
        end
        wr(a, d);
    endtask

    initial begin
        #(20 * 150000);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] r;
        void'($urandom(32'h5eed));
        for (int f = 0; f < 12; f++) begin
            m_stg[f] = b_rst(f);
            m_act[f] = b_rst(f);
        end
        m_err = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R9: reset state
        check_all("R9 reset");
        chk("R9 tick reset", int'(tick_ratio), 8);
        chk("R9 periph reset", int'(periph_ratio), 16);

        // R2: value bits without write enable
        wr(8'h00, 32'h0000_0003);
        chk("R2 no enable", int'(tick_ratio), 8);
        // R3: immediate update
        wr(8'h00, 32'h0000_0007);
        chk("R3 tick immediate", int'(tick_ratio), 32);
        rd(8'h00, r);
        chk("R10 enable bit reads 0", int'(r), 3);
        wr(8'h00, (32'd1 << 30) | (32'd3 << 28));
        chk("R6 card code 3", int'(card_ratio), 15);
        chk("R2 tick untouched", int'(tick_ratio), 32);
        wr(8'h00, (32'd1 << 27) | (32'd8 << 22));
        chk("R7 flash code 8", int'(flash_src), 5);
        wr(8'h1C, (32'd1 << 5) | (32'd2 << 3));
        chk("R7 serial code 2", int'(serial_src), 2);
        check_all("R3 directed");

        // R4: staged write stays hidden
        wr(8'h20, (32'd1 << 6) | 32'd31);
        chk("R4 periph held", int'(periph_ratio), 16);
        check_all("R4 staged");
        wr(8'h28, 32'h1);
        wait_commit(0, "first");
        chk("R5 periph applied", int'(periph_ratio), 32);

        // R8: refused code, neighbour still updates
        wr(8'h20, (32'd1 << 19) | (32'd6 << 16) | (32'd1 << 23) | (32'd7 << 20));
        rd(8'h2C, r);
        chk("R8 error set", int'(r), 1);
        wr(8'h00, (32'd1 << 27) | (32'd5 << 22));
        chk("R8 flash kept", int'(flash_src), 5);
        wr(8'h28, 32'h1);
        wait_commit(0, "refused");
        chk("R8 ext kept", int'(ext_ratio), 4);
        chk("R8 core updated", int'(core_ratio), 8);
        wr(8'h2C, 32'h0);
        rd(8'h2C, r);
        chk("R8 sticky", int'(r), 1);
        wr(8'h2C, 32'h1);
        rd(8'h2C, r);
        chk("R8 cleared", int'(r), 0);

        // R1: misaligned and unmapped accesses
        wr(8'h21, 32'hFFFF_FFFF);
        wr(8'h04, 32'hFFFF_FFFF);
        wr(8'h01, 32'hFFFF_FFFF);
        rd(8'h22, r);
        chk("R1 misaligned read", int'(r), 0);
        check_all("R1 ignored");

        // R5: request while pending, staged change mid-commit
        wr(8'h28, 32'h1);
        repeat (7) @(negedge clk);
        wr(8'h24, (32'd1 << 9) | (32'd3 << 7) | (32'd1 << 2) | 32'd3);
        wr(8'h28, 32'h1);
        wait_commit(9, "overlap");
        chk("R5 memhi late stage", int'(memhi_ratio), 4);
        wr(8'h28, 32'h0);
        rd(8'h28, r);
        chk("R5 no request", int'(r), 0);

        // random mix
        for (int it = 0; it < 400; it++) begin
            rand_write();
            check_all("random R2");
            if (it % 40 == 39) begin
                wr(8'h28, 32'h1);
                wait_commit(0, "random");
            end
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule